// File: doc/BRIEF.md
# Trigger Input Conditioner with Noise Filter and Programmable Delay

This block conditions the external trigger pins that start and stop a timer's one-shot output mode. Each pin is brought into the system clock domain by a two-flop synchronizer. It then passes a majority-free noise filter: a new level is accepted only after three consecutive equal samples, taken on a sampling tick derived from the system clock.

Each channel has an enable bit and a polarity bit. A channel is armed only after its filtered level has been seen at the inactive level while the channel is enabled. An active edge on an armed channel starts a programmable delay. When the delay expires, the channel emits a one-cycle trigger pulse. A new active edge that arrives during the countdown restarts it. A single halving control both switches the filter to its alternate sampling rate and halves the programmed delay.

Top module: `trig_cond`

## Requirements
- R1: A change on `pin_i` reaches the filtered level only after it has been sampled equal on three consecutive sampling ticks. Sampling uses the doubly synchronized pin value, so a change driven before edge k can first be sampled at a tick on edge k+2.
- R2: The sampling ticks come from a free-running 2-bit counter that is cleared by reset and advances on every edge. Define the effective select as `slow_sel_i` XOR `half_i`. When the effective select is 0, a tick falls on every edge taken with the counter's low bit at 1 (period 2). When it is 1, a tick falls on every edge taken with the counter at 3 (period 4). Two ticks are never adjacent.
- R3: `dly_sel_i` selects the trigger delay D: 0 gives 0 cycles, 1 gives 4, 2 gives 8 and 3 gives 16.
- R4: When `half_i` is 1, D is half of the R3 value (0, 2, 4 or 8).
- R5: With `rise_i` = 1 the active level is high; with `rise_i` = 0 it is low. An edge to the active level fires only if the filtered level has been at the inactive level while the channel was enabled. A pin already at its active level when the channel is enabled produces no pulse.
- R6: A channel whose `en_i` bit is 0 produces no pulse, and clearing the bit cancels any delay in progress.
- R7: An accepted active edge during a running countdown restarts the countdown with the current D. The earlier pending pulse is dropped.
- R8: Suppose the third qualifying tick is on edge t3. Then `trig_o` is high for exactly one cycle, rising at edge t3+1+D.
- R9: During and right after reset, `trig_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_CH | Raw trigger pins |
| slow_sel_i | input | 1 | Sampling clock select (0: /2, 1: /4) |
| dly_sel_i | input | 2 | Delay code |
| half_i | input | 1 | Alternate sampling clock and halved delay |
| en_i | input | NUM_CH | Per-channel enable |
| rise_i | input | NUM_CH | Per-channel polarity, 1 = rising edge active |
| trig_o | output | NUM_CH | One-cycle delayed trigger pulses |

## Verification
The hardest situation to reach is a restarted countdown. A second accepted active edge must land before the first delay expires. That requires the pin to go inactive and active again, and each change must pass the synchronizer and three filter ticks. The bench uses the longest delay with the fastest sampling. It toggles the pin every six cycles, so each level is held for exactly three ticks. It checks that only the pulse computed from the last edge appears. The arming rule is reached by enabling a channel while its pin already rests at the active level.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;
  localparam int unsigned DLY_W = 5;

  // delay code to cycles, optionally halved
  function automatic logic [DLY_W-1:0] dly_cycles(input logic [1:0] code, input logic half);
    logic [DLY_W-1:0] base;
    case (code)
      2'd0:    base = DLY_W'(0);
      2'd1:    base = DLY_W'(4);
      2'd2:    base = DLY_W'(8);
      default: base = DLY_W'(16);
    endcase
    return half ? (base >> 1) : base;
  endfunction
endpackage

// File: rtl/trig_prescale.sv
module trig_prescale #(
  parameter int unsigned PW = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + PW'(1);
  end

  assign tick_o = slow_i ? (&cnt_q) : cnt_q[0];
endmodule

// File: rtl/trig_filter.sv
module trig_filter #(
  parameter int unsigned SYNC_LEN = 2,
  parameter int unsigned HIST     = 3   // at least 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tick_i,
  output logic lvl_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [HIST-2:0]     hist_q;
  logic                smp;
  logic                all_eq;

  assign smp    = sync_q[SYNC_LEN-1];
  assign all_eq = (hist_q == {(HIST-1){smp}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_LEN-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      lvl_o  <= 1'b0;
    end else if (tick_i) begin
      hist_q <= {hist_q[HIST-3:0], smp};
      if (all_eq) lvl_o <= smp;
    end
  end
endmodule

// File: rtl/trig_fire.sv
module trig_fire
  import trig_cond_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             pulse_o
);
  logic             armed_q;
  logic [DLY_W-1:0] cnt_q;
  logic             active, evt, fire;

  assign active = rise_i ? lvl_i : ~lvl_i;
  assign evt    = en_i & armed_q & active;
  assign fire   = en_i & ((evt & (dly_i == '0)) | (~evt & (cnt_q == DLY_W'(1))));

  // arm only after the inactive level is seen while enabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (!en_i)   armed_q <= 1'b0;
    else if (!active) armed_q <= 1'b1;
    else if (evt)     armed_q <= 1'b0;
  end

  // restartable countdown
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (evt)            cnt_q <= dly_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - DLY_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= fire;
  end
endmodule

// File: rtl/trig_cond.sv
module trig_cond
  import trig_cond_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              slow_sel_i,
  input  logic [1:0]        dly_sel_i,
  input  logic              half_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] rise_i,
  output logic [NUM_CH-1:0] trig_o
);
  logic              tick;
  logic [NUM_CH-1:0] lvl;
  logic [DLY_W-1:0]  dly;

  assign dly = dly_cycles(dly_sel_i, half_i);

  // halving control also flips the sampling rate
  trig_prescale u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slow_i(slow_sel_i ^ half_i),
    .tick_o(tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    trig_filter u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_i[i]),
      .tick_i(tick),
      .lvl_o (lvl[i])
    );

    trig_fire u_fire (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl[i]),
      .en_i   (en_i[i]),
      .rise_i (rise_i[i]),
      .dly_i  (dly),
      .pulse_o(trig_o[i])
    );
  end
endmodule

// File: rtl/trig_cond_chk.sv
module trig_cond_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] en_i,
  input logic [NUM_CH-1:0] trig_o,
  input logic              tick_i,
  input logic [NUM_CH-1:0] lvl_i
);
  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_en_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o[i] |-> $past(en_i[i]));

    assert_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o[i] |=> !trig_o[i]);

    assert_filt_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_i[i] != $past(lvl_i[i])) |-> $past(tick_i));
  end
endmodule

bind trig_cond trig_cond_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .trig_o(trig_o),
  .tick_i(tick),
  .lvl_i (lvl)
);

// File: tb/trig_cond_test.sv
`timescale 1ns/1ps
module trig_cond_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pin = 2'b00;
  logic       slow = 1'b0;
  logic [1:0] dsel = 2'd0;
  logic       half = 1'b0;
  logic [1:0] en = 2'b00;
  logic [1:0] rise = 2'b00;
  logic [1:0] trig;

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  int pcnt[2];
  int plast[2];

  always #2 clk = ~clk;

  trig_cond #(.NUM_CH(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .slow_sel_i(slow),
    .dly_sel_i(dsel), .half_i(half), .en_i(en), .rise_i(rise), .trig_o(trig)
  );

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  initial begin pcnt[0] = 0; pcnt[1] = 0; plast[0] = 0; plast[1] = 0; end
  always @(negedge clk) begin
    for (int c = 0; c < 2; c++)
      if (trig[c]) begin pcnt[c] = pcnt[c] + 1; plast[c] = cyc; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input int ch, input logic v, output int k);
    @(negedge clk);
    k = cyc + 1;
    pin[ch] = v;
  endtask

  // R3/R4 delay in cycles
  function automatic int exp_dly();
    int b;
    b = (dsel == 2'd0) ? 0 : (2 << dsel);
    return half ? b / 2 : b;
  endfunction

  // R2 tick on edge n when ((n-1) & m) == m
  function automatic int next_tick(input int n, input int m);
    int x = n;
    while (((x - 1) & m) != m) x++;
    return x;
  endfunction

  // R1/R8 expected pulse edge for a pin change driven before edge k
  function automatic int exp_edge(input int k);
    int m, t1, t2, t3;
    m  = (slow ^ half) ? 3 : 1;
    t1 = next_tick(k + 2, m);
    t2 = next_tick(t1 + 1, m);
    t3 = next_tick(t2 + 1, m);
    return t3 + 1 + exp_dly();
  endfunction

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int k, k2, k3, e, b0, b1;
    // R9 reset state
    idle(3);
    check(trig == 2'b00, "R9 trig in reset", int'(trig), 0);
    @(negedge clk) rst_ni = 1'b1;
    idle(2);
    check(trig == 2'b00, "R9 trig after reset", int'(trig), 0);

    // sweep: R1 R2 R3 R4 R5 R8 over all configurations and both channels
    for (int cfg = 0; cfg < 32; cfg++) begin
      for (int ch = 0; ch < 2; ch++) begin
        en = 2'b00;
        idle(2);
        slow = cfg[0]; half = cfg[1]; dsel = cfg[3:2]; rise[ch] = cfg[4];
        pin[ch] = ~cfg[4];
        idle(2);
        b0 = pcnt[0]; b1 = pcnt[1];
        en[ch] = 1'b1;
        idle(50);
        check(pcnt[0] == b0 && pcnt[1] == b1, "R5 no pulse while arming",
              pcnt[0] + pcnt[1] - b0 - b1, 0);
        b0 = pcnt[ch]; b1 = pcnt[1 - ch];
        drive(ch, cfg[4], k);
        e = exp_edge(k);
        idle(60);
        check(pcnt[ch] - b0 == 1, "R8 one pulse per edge", pcnt[ch] - b0, 1);
        check(plast[ch] == e, "R3/R4 R8 pulse edge", plast[ch], e);
        check(pcnt[1 - ch] == b1, "R6 other channel silent", pcnt[1 - ch] - b1, 0);
      end
    end

    // R5: pin already active when enabled gives no pulse
    en = 2'b00; slow = 1'b0; half = 1'b0; dsel = 2'd1; rise[0] = 1'b1;
    pin[0] = 1'b1;
    idle(30);
    b0 = pcnt[0];
    en[0] = 1'b1;
    idle(40);
    check(pcnt[0] == b0, "R5 active at enable ignored", pcnt[0] - b0, 0);
    drive(0, 1'b0, k);
    idle(30);
    check(pcnt[0] == b0, "R5 inactive edge no pulse", pcnt[0] - b0, 0);
    drive(0, 1'b1, k);
    e = exp_edge(k);
    idle(40);
    check(pcnt[0] - b0 == 1 && plast[0] == e, "R5 armed edge fires", plast[0], e);

    // R6: disabled channel ignores edges
    en = 2'b00; rise[1] = 1'b1; pin[1] = 1'b0;
    idle(30);
    b1 = pcnt[1];
    drive(1, 1'b1, k);
    idle(60);
    check(pcnt[1] == b1, "R6 disabled no pulse", pcnt[1] - b1, 0);

    // R6: clearing enable cancels a pending delay
    dsel = 2'd3; rise[1] = 1'b1; pin[1] = 1'b0; en[1] = 1'b1;
    idle(30);
    b1 = pcnt[1];
    drive(1, 1'b1, k);
    idle(12);
    en[1] = 1'b0;
    idle(40);
    check(pcnt[1] == b1, "R6 disable cancels delay", pcnt[1] - b1, 0);

    // R7: retrigger during countdown, falling-edge channel, D=16, /2 sampling
    en = 2'b00; slow = 1'b0; half = 1'b0; dsel = 2'd3; rise[1] = 1'b0; pin[1] = 1'b1;
    idle(4);
    en[1] = 1'b1;
    idle(30);
    b1 = pcnt[1];
    drive(1, 1'b0, k);
    idle(5);
    drive(1, 1'b1, k2);
    idle(5);
    drive(1, 1'b0, k3);
    e = exp_edge(k3);
    idle(60);
    check(pcnt[1] - b1 == 1, "R7 single pulse after restart", pcnt[1] - b1, 1);
    check(plast[1] == e, "R7 pulse from last edge", plast[1], e);
    check(k2 - k == 6, "R7 stimulus spacing", k2 - k, 6);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule